// File: doc/BRIEF.md
# Interval Type-2 Trapezoidal Membership Evaluator

This block grades a crisp 16-bit sample against one interval type-2 trapezoidal fuzzy set. It returns two 16-bit membership grades. The upper grade comes from a unit-height trapezoid. The lower grade comes from a second, narrower trapezoid whose plateau sits at a programmable height. Grades are fixed-point fractions in which 0000h is zero and FFFFh stands for full membership.

A pulse on `start` captures the sample and all nine shape parameters. Each trapezoid then has its own classifier, which finds the segment the sample lies in: outside, rising edge, plateau or falling edge. On a sloped edge the classifier builds a numerator and denominator, and that path's own successive-approximation fractional divider resolves three quotient bits per cycle. The upper and lower paths run side by side with identical latency. The lower slope result is scaled by the height parameter. One `valid` pulse presents both grades together, and they are held until the next result.

Top module: `it2_trap_fuzzifier`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `valid` are 0 and both grades read 0000h.
- R2: For either trapezoid, a sample below its left foot, or equal to or above its right foot, gives that trapezoid a grade of 0000h.
- R3: On the upper rising edge (up_foot_l <= x < up_shld_l), upper_grade = floor((x - up_foot_l) * 65536 / (up_shld_l - up_foot_l)).
- R4: On the upper falling edge (up_shld_r < x < up_foot_r), upper_grade = floor((up_foot_r - x) * 65536 / (up_foot_r - up_shld_r)).
- R5: On a plateau (left shoulder <= x <= right shoulder), upper_grade is FFFFh and lower_grade equals lo_height.
- R6: On a lower edge, lower_grade = floor(f * (lo_height + 1) / 65536). Here f is the R3/R4 fraction formed from the lo_* points. So lo_height = FFFFh returns f unchanged, and lower_grade never exceeds lo_height.
- R7: Boundaries are inclusive on the shoulder side. A shoulder equal to its foot acts as a vertical edge, so the sample at that point is on the plateau and no division by zero occurs.
- R8: Both grades are produced together. `valid` is a single-cycle pulse that is high exactly 7 clock cycles after the rising edge that accepted `start`, and `busy` is low while `valid` is high.
- R9: `start` is ignored while `busy` is high. Sample and parameters are captured when `start` is accepted, so later changes to them do not affect the result in flight.
- R10: Between `valid` pulses, upper_grade and lower_grade hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new evaluation; accepted when not busy |
| x_in | input | 16 | Crisp sample |
| up_foot_l | input | 16 | Upper trapezoid left foot |
| up_shld_l | input | 16 | Upper trapezoid left shoulder |
| up_shld_r | input | 16 | Upper trapezoid right shoulder |
| up_foot_r | input | 16 | Upper trapezoid right foot |
| lo_foot_l | input | 16 | Lower trapezoid left foot |
| lo_shld_l | input | 16 | Lower trapezoid left shoulder |
| lo_shld_r | input | 16 | Lower trapezoid right shoulder |
| lo_foot_r | input | 16 | Lower trapezoid right foot |
| lo_height | input | 16 | Lower trapezoid plateau height |
| busy | output | 1 | Evaluation in progress |
| valid | output | 1 | One-cycle pulse marking new grades |
| upper_grade | output | 16 | Upper membership grade |
| lower_grade | output | 16 | Lower membership grade |

## Verification
The sample is swept across a fixed nested pair of trapezoids so that the two paths fall in different segments at once, for example the upper plateau against a lower edge. This shows that each path classifies on its own points and not on the other's. Samples placed exactly on every foot and shoulder, and trapezoids with a vertical edge, pin down the inclusive boundary rules and the zero-width denominator case. Full height and fractional heights separate the height scaling from the bare quotient. A run of pseudo-random ordered shapes exercises the divider digits broadly. An overlapped start with altered inputs confirms that the captured operands are the ones graded.

// File: rtl/it2_fuzz_pkg.sv
package it2_fuzz_pkg;

  // Segment of a trapezoid that the sample falls in
  typedef enum logic [1:0] {
    SEG_OUT  = 2'd0,
    SEG_RISE = 2'd1,
    SEG_FLAT = 2'd2,
    SEG_FALL = 2'd3
  } seg_e;

endpackage

// File: rtl/trap_seg.sv
module trap_seg
  import it2_fuzz_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] foot_l,
  input  logic [W-1:0] shld_l,
  input  logic [W-1:0] shld_r,
  input  logic [W-1:0] foot_r,
  output seg_e         seg,
  output logic [W-1:0] num,
  output logic [W-1:0] den
);

  // Shoulder side inclusive; equal foot/shoulder never selects a slope
  always_comb begin
    seg = SEG_OUT;
    num = '0;
    den = W'(1);
    if (x < foot_l || x >= foot_r) begin
      seg = SEG_OUT;
    end else if (x < shld_l) begin
      seg = SEG_RISE;
      num = x - foot_l;
      den = shld_l - foot_l;
    end else if (x <= shld_r) begin
      seg = SEG_FLAT;
    end else begin
      seg = SEG_FALL;
      num = foot_r - x;
      den = foot_r - shld_r;
    end
  end

endmodule

// File: rtl/sa_frac_div.sv
module sa_frac_div #(
  parameter int W  = 16,
  parameter int RB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);

  localparam int ITER = (W + RB - 1) / RB;
  localparam int QW   = ITER * RB;
  localparam int CW   = $clog2(ITER + 1);
  localparam int NK   = 1 << RB;
  localparam int XW   = W + RB;

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  den_q, den_n;
  logic [QW-1:0] q_q, q_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, run_n;
  logic          done_q, done_n;

  logic [XW-1:0] rem_x;
  logic [XW-1:0] mult [NK];
  logic [NK-1:0] hit;
  logic [RB-1:0] digit;
  logic [XW-1:0] diff;

  assign rem_x = {rem_q, {RB{1'b0}}};

  // Region bounds: every multiple of the divisor up to NK-1
  genvar gk;
  generate
    for (gk = 0; gk < NK; gk++) begin : g_reg
      assign mult[gk] = XW'(den_q) * XW'(gk);
      assign hit[gk]  = (rem_x >= mult[gk]);
    end
  endgenerate

  // Highest region the scaled remainder reaches
  always_comb begin
    digit = '0;
    for (int k = 1; k < NK; k++) begin
      if (hit[k]) digit = RB'(k);
    end
  end

  assign diff = rem_x - mult[digit];

  always_comb begin
    rem_n  = rem_q;
    den_n  = den_q;
    q_n    = q_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (load) begin
      rem_n = num;
      den_n = den;
      q_n   = '0;
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_q) begin
      rem_n = diff[W-1:0];
      q_n   = {q_q[QW-RB-1:0], digit};
      cnt_n = cnt_q + CW'(1);
      if (cnt_q == CW'(ITER - 1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      den_q  <= den_n;
      q_q    <= q_n;
      cnt_q  <= cnt_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign quo  = q_q[QW-1 -: W];

endmodule

// File: rtl/it2_trap_fuzzifier.sv
module it2_trap_fuzzifier
  import it2_fuzz_pkg::*;
#(
  parameter int W  = 16,
  parameter int RB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] up_foot_l,
  input  logic [W-1:0] up_shld_l,
  input  logic [W-1:0] up_shld_r,
  input  logic [W-1:0] up_foot_r,
  input  logic [W-1:0] lo_foot_l,
  input  logic [W-1:0] lo_shld_l,
  input  logic [W-1:0] lo_shld_r,
  input  logic [W-1:0] lo_foot_r,
  input  logic [W-1:0] lo_height,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] upper_grade,
  output logic [W-1:0] lower_grade
);

  localparam logic [W-1:0] FULL = '1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // Classification straight from the ports; captured on acceptance
  seg_e         seg_u_c, seg_l_c;
  logic [W-1:0] num_u, den_u, num_l, den_l;

  trap_seg #(.W(W)) u_seg_up (
    .x(x_in), .foot_l(up_foot_l), .shld_l(up_shld_l),
    .shld_r(up_shld_r), .foot_r(up_foot_r),
    .seg(seg_u_c), .num(num_u), .den(den_u)
  );

  trap_seg #(.W(W)) u_seg_lo (
    .x(x_in), .foot_l(lo_foot_l), .shld_l(lo_shld_l),
    .shld_r(lo_shld_r), .foot_r(lo_foot_r),
    .seg(seg_l_c), .num(num_l), .den(den_l)
  );

  logic accept;
  assign accept = start && !busy_q;

  logic         done_u, done_l;
  logic [W-1:0] quo_u, quo_l;

  sa_frac_div #(.W(W), .RB(RB)) u_div_up (
    .clk(clk), .rst_n(rst_i_n), .load(accept),
    .num(num_u), .den(den_u), .done(done_u), .quo(quo_u)
  );

  sa_frac_div #(.W(W), .RB(RB)) u_div_lo (
    .clk(clk), .rst_n(rst_i_n), .load(accept),
    .num(num_l), .den(den_l), .done(done_l), .quo(quo_l)
  );

  // Held state
  logic         busy_q, busy_n;
  logic         valid_q, valid_n;
  seg_e         seg_u_q, seg_u_n, seg_l_q, seg_l_n;
  logic [W-1:0] ht_q, ht_n;
  logic [W-1:0] up_q, up_n, lo_q, lo_n;

  // Height scaling: (quotient * (height + 1)) upper W bits
  logic [2*W:0] prod;
  assign prod = {{(W+1){1'b0}}, quo_l} * {{W{1'b0}}, 1'b0, ht_q} + {{(W+1){1'b0}}, quo_l};

  logic [W-1:0] up_grade_c, lo_grade_c;

  always_comb begin
    case (seg_u_q)
      SEG_FLAT:          up_grade_c = FULL;
      SEG_RISE, SEG_FALL: up_grade_c = quo_u;
      default:           up_grade_c = '0;
    endcase
    case (seg_l_q)
      SEG_FLAT:          lo_grade_c = ht_q;
      SEG_RISE, SEG_FALL: lo_grade_c = prod[2*W-1:W];
      default:           lo_grade_c = '0;
    endcase
  end

  always_comb begin
    busy_n  = busy_q;
    valid_n = 1'b0;
    seg_u_n = seg_u_q;
    seg_l_n = seg_l_q;
    ht_n    = ht_q;
    up_n    = up_q;
    lo_n    = lo_q;
    if (accept) begin
      busy_n  = 1'b1;
      seg_u_n = seg_u_c;
      seg_l_n = seg_l_c;
      ht_n    = lo_height;
    end else if (busy_q && done_u && done_l) begin
      busy_n  = 1'b0;
      valid_n = 1'b1;
      up_n    = up_grade_c;
      lo_n    = lo_grade_c;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      seg_u_q <= SEG_OUT;
      seg_l_q <= SEG_OUT;
      ht_q    <= '0;
      up_q    <= '0;
      lo_q    <= '0;
    end else begin
      busy_q  <= busy_n;
      valid_q <= valid_n;
      seg_u_q <= seg_u_n;
      seg_l_q <= seg_l_n;
      ht_q    <= ht_n;
      up_q    <= up_n;
      lo_q    <= lo_n;
    end
  end

  assign busy        = busy_q;
  assign valid       = valid_q;
  assign upper_grade = up_q;
  assign lower_grade = lo_q;

endmodule

// File: rtl/it2_fuzz_chk.sv
module it2_fuzz_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         valid,
  input logic [W-1:0] upper_grade,
  input logic [W-1:0] lower_grade,
  input logic [W-1:0] held_height
);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_valid_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);

  p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_hold_grades_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(upper_grade) && $stable(lower_grade)));

  p_lower_capped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (lower_grade <= held_height));

endmodule

bind it2_trap_fuzzifier it2_fuzz_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid),
  .upper_grade(upper_grade), .lower_grade(lower_grade), .held_height(ht_q)
);

// File: tb/it2_trap_fuzzifier_tb.sv
`timescale 1ns/1ps
module it2_trap_fuzzifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xv = '0;
  logic [15:0] p [1:9];
  logic        busy, valid;
  logic [15:0] upper_grade, lower_grade;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lcg = 32'h1234_5678;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  it2_trap_fuzzifier u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(xv),
    .up_foot_l(p[5]), .up_shld_l(p[6]), .up_shld_r(p[7]), .up_foot_r(p[8]),
    .lo_foot_l(p[1]), .lo_shld_l(p[2]), .lo_shld_r(p[3]), .lo_foot_r(p[4]),
    .lo_height(p[9]), .busy(busy), .valid(valid),
    .upper_grade(upper_grade), .lower_grade(lower_grade)
  );

  // Scoreboard entries
  logic [15:0] exp_up_q [$];
  logic [15:0] exp_lo_q [$];
  string       tag_q [$];
  int          t0_q [$];

  // 65536 marks plateau, otherwise the 16-bit fraction
  function automatic longint raw_mu(longint x, longint lf, longint ls, longint rs, longint rf);
    if (x < lf || x >= rf) return 0;
    if (x < ls) return ((x - lf) * 65536) / (ls - lf);
    if (x <= rs) return 65536;
    return ((rf - x) * 65536) / (rf - rs);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(string tag, logic [15:0] xs, logic [15:0] pp [1:9], bit overlap);
    longint ru, rl, h;
    @(negedge clk);
    xv = xs;
    for (int i = 1; i <= 9; i++) p[i] = pp[i];
    ru = raw_mu(xs, pp[5], pp[6], pp[7], pp[8]);
    rl = raw_mu(xs, pp[1], pp[2], pp[3], pp[4]);
    h  = pp[9];
    exp_up_q.push_back(ru == 65536 ? 16'hFFFF : 16'(ru));
    exp_lo_q.push_back(rl == 65536 ? 16'(h) : 16'((rl * (h + 1)) >> 16));
    tag_q.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0_q.push_back(cyc);
    if (overlap) begin
      // R9: new inputs and a second start while busy
      @(negedge clk);
      xv = 16'h0000;
      for (int i = 1; i <= 9; i++) p[i] = 16'h0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_up_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor
  logic [15:0] last_up, last_lo;
  bit          have_last = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (exp_up_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual extra valid expected none");
        end else begin
          string t;
          int t0;
          t = tag_q.pop_front();
          t0 = t0_q.pop_front();
          check({t, " upper"}, upper_grade, exp_up_q.pop_front());
          check({t, " lower"}, lower_grade, exp_lo_q.pop_front());
          check("R8 latency", cyc - t0, 7);
          check("R8 busy low at valid", busy, 0);
        end
        last_up = upper_grade;
        last_lo = lower_grade;
        have_last = 1;
      end else if (have_last) begin
        check("R10 upper hold", upper_grade, last_up);
        check("R10 lower hold", lower_grade, last_lo);
      end
    end
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [15:0] nxt();
    lcg = lcg * 1103515245 + 12345;
    return 16'(lcg >>> 8);
  endfunction

  initial begin
    logic [15:0] b [1:9];
    logic [15:0] v [4];
    for (int i = 1; i <= 9; i++) p[i] = '0;
    repeat (5) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 valid", valid, 0);
    check("R1 upper", upper_grade, 0);
    check("R1 lower", lower_grade, 0);

    b[5] = 1000; b[6] = 3000; b[7] = 6000; b[8] = 9000;
    b[1] = 1500; b[2] = 3500; b[3] = 5500; b[4] = 8000; b[9] = 16'hC000;
    run("R2 below feet", 500, b, 0);
    run("R3 R6 rising", 2000, b, 0);
    run("R5 plateau", 4000, b, 0);
    run("R4 R6 falling", 7000, b, 0);
    run("R2 above feet", 9500, b, 0);
    run("R7 R2 left foot", 1000, b, 0);
    run("R7 R5 R6 upper shoulder", 3000, b, 0);
    run("R7 R5 R6 right shoulder", 6000, b, 0);
    run("R7 R2 R4 lower foot", 8000, b, 0);
    run("R7 R2 upper right foot", 9000, b, 0);
    run("R3 R6 near shoulder", 2999, b, 0);
    b[9] = 16'hFFFF;
    run("R6 full height", 2000, b, 0);
    b[9] = 16'h0001;
    run("R6 tiny height", 7500, b, 0);
    b[9] = 16'h8000;
    b[6] = 1000; b[2] = 1500;
    run("R7 vertical left", 1000, b, 0);
    run("R7 vertical left lo", 1500, b, 0);
    b[7] = 9000; b[3] = 8000;
    run("R7 R2 vertical right", 9000, b, 0);
    b[5] = 1000; b[6] = 3000; b[7] = 6000; b[8] = 9000;
    b[1] = 1500; b[2] = 3500; b[3] = 5500; b[4] = 8000;
    run("R9 overlap start", 2500, b, 1);

    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) v[i] = nxt();
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3 - i; j++)
          if (v[j] > v[j+1]) begin
            logic [15:0] s;
            s = v[j]; v[j] = v[j+1]; v[j+1] = s;
          end
      b[5] = v[0]; b[6] = v[1]; b[7] = v[2]; b[8] = v[3];
      b[1] = v[0] + ((v[1] - v[0]) >> 1);
      b[2] = v[1];
      b[3] = v[2];
      b[4] = v[2] + ((v[3] - v[2]) >> 1);
      b[9] = nxt();
      run("R3 R4 R6 random", nxt(), b, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule